// File: doc/BRIEF.md
# Programmable Tapped Delay Line

The block delays a data word by a number of clock cycles that is chosen at run time. A chain of registers moves the incoming word one stage along on every enabled clock edge. A multiplexer picks one point of that chain as the output, and a delay-control input steers it. The delay can be set anywhere from zero cycles up to the length of the chain. At a setting of zero the input goes straight to the output with no register in between.

Each stage can be read at any time, so a change of setting takes effect on the very next output. The chain is not flushed. The output at once shows whatever word the newly chosen stage holds.

When the enable is low the whole chain holds its contents. Delays are therefore counted in enabled cycles. Reset is synchronous and active high, and it clears every stage to zero.

Top module: `tdl_top`

## Requirements
- R1: On a clock edge with `rst` high, every stage becomes zero. Afterwards every nonzero setting of `tap_sel` shows zero on `dout` until new data has been shifted that far.
- R2: When `tap_sel` is 0, `dout` equals `din` in the same cycle, with no register in the path.
- R3: When `tap_sel` is d, with d from 1 to 63, and `en` has been high, `dout` equals the `din` word captured d enabled edges earlier.
- R4: On an edge where `en` is low, no stage changes. For a fixed nonzero `tap_sel`, `dout` stays the same whatever `din` does.
- R5: A new `tap_sel` value acts on the same cycle's output with no flush. `dout` at once equals the word the newly selected stage holds. For example, if the setting grows by one across an enabled edge, `dout` is unchanged.
- R6: The largest setting, 63, gives a delay of exactly 63 enabled cycles.
- R7: All 64 codes of the 6-bit `tap_sel` are valid. Code k (1 to 63) reads stage k, which holds the word entered k enabled edges ago, and code 0 selects the bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages update on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all stages |
| en | input | 1 | Shift enable; low holds every stage |
| din | input | 8 | Input data word |
| tap_sel | input | 6 | Delay setting in cycles, 0 to 63 |
| dout | output | 8 | Delayed data word |

## Verification
The two functions that share a cycle are the chain shift and a change of the tap setting. When the setting moves across an enabled edge, the output must come from the new stage after that edge's shift, not from the old stage or from a pre-shift copy. The random phase changes the setting on about a quarter of the cycles while the enable toggles at random. Each output is judged against a bench history buffer that shifts only on enabled edges and is indexed by the current setting.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    localparam int TDL_DATA_W    = 8;
    localparam int TDL_MAX_DELAY = 63;

    function automatic int tdl_sel_width(input int max_delay);
        return (max_delay < 1) ? 1 : $clog2(max_delay + 1);
    endfunction

endpackage

// File: rtl/tdl_stage_chain.sv
module tdl_stage_chain #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 63
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [WIDTH-1:0]              din,
    output logic [STAGES-1:0][WIDTH-1:0]  taps
);

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        taps[s] <= '0;
                    end else if (en) begin
                        taps[s] <= din;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        taps[s] <= '0;
                    end else if (en) begin
                        taps[s] <= taps[s-1];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 63,
    parameter int SEL_W  = 6
) (
    input  logic [WIDTH-1:0]              din,
    input  logic [STAGES-1:0][WIDTH-1:0]  taps,
    input  logic [SEL_W-1:0]              sel,
    output logic [WIDTH-1:0]              dout
);

    always_comb begin
        dout = din;
        for (int k = 1; k <= STAGES; k++) begin
            if (sel == SEL_W'(k)) begin
                dout = taps[k-1];
            end
        end
    end

endmodule

// File: rtl/tdl_top.sv
module tdl_top #(
    parameter int WIDTH     = tdl_pkg::TDL_DATA_W,
    parameter int MAX_DELAY = tdl_pkg::TDL_MAX_DELAY,
    parameter int SEL_W     = tdl_pkg::tdl_sel_width(MAX_DELAY)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    input  logic [SEL_W-1:0] tap_sel,
    output logic [WIDTH-1:0] dout
);

    logic [MAX_DELAY-1:0][WIDTH-1:0] stage_q;

    tdl_stage_chain #(
        .WIDTH  (WIDTH),
        .STAGES (MAX_DELAY)
    ) u_chain (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .din  (din),
        .taps (stage_q)
    );

    tdl_tap_mux #(
        .WIDTH  (WIDTH),
        .STAGES (MAX_DELAY),
        .SEL_W  (SEL_W)
    ) u_mux (
        .din  (din),
        .taps (stage_q),
        .sel  (tap_sel),
        .dout (dout)
    );

endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
    parameter int WIDTH     = 8,
    parameter int MAX_DELAY = 63,
    parameter int SEL_W     = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [WIDTH-1:0] din,
    input logic [SEL_W-1:0] tap_sel,
    input logic [WIDTH-1:0] dout
);

    logic live_q;

    always_ff @(posedge clk) begin
        live_q <= !rst;
    end

    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (tap_sel == '0) |-> (dout == din));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && tap_sel != '0) |-> (dout == '0));

    assert_one_stage_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(en) && tap_sel == SEL_W'(1)) |-> (dout == $past(din)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(en) && $stable(tap_sel) && tap_sel != '0) |-> $stable(dout));

    assert_retarget_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(en) &&
         ({1'b0, tap_sel} == ({1'b0, $past(tap_sel)} + 1'b1))) |-> (dout == $past(dout)));

endmodule

bind tdl_top tdl_checker #(
    .WIDTH     (WIDTH),
    .MAX_DELAY (MAX_DELAY),
    .SEL_W     (SEL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .din     (din),
    .tap_sel (tap_sel),
    .dout    (dout)
);

// File: tb/sim_tdl_top.sv
module sim_tdl_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int D  = 63;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [W-1:0]  din = '0;
    logic [SW-1:0] tap_sel = '0;
    logic [W-1:0]  dout;

    logic [W-1:0]  hist [0:D-1];
    int            errors = 0;
    int            checks = 0;

    tdl_top u0 (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .din     (din),
        .tap_sel (tap_sel),
        .dout    (dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] model_out(input logic [SW-1:0] s, input logic [W-1:0] d);
        if (s == '0) return d;
        return hist[int'(s) - 1];
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout actual=%0h expected=%0h (tap_sel=%0d)", tag, act, exp, tap_sel);
        end
    endtask

    task automatic step(input logic e, input logic r, input logic [W-1:0] d,
                        input logic [SW-1:0] s, input bit do_chk, input string tag);
        @(negedge clk);
        en = e; rst = r; din = d; tap_sel = s;
        #1;
        if (do_chk) check(tag, dout, model_out(s, d));
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < D; k++) hist[k] = '0;
        end else if (e) begin
            for (int k = D-1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = d;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < D; k++) hist[k] = '0;

        // Reset, then every setting must read zero (R1, R7)
        step(1'b1, 1'b1, 8'hAA, 6'd5, 1'b0, "R1");
        step(1'b1, 1'b1, 8'h55, 6'd9, 1'b0, "R1");
        for (int s = 1; s < 64; s++) step(1'b0, 1'b0, W'($urandom), SW'(s), 1'b1, "R1");

        // Bypass: same-cycle pass-through (R2)
        for (int i = 0; i < 12; i++) step(1'($urandom), 1'b0, W'($urandom), 6'd0, 1'b1, "R2");

        // Longest setting through a full fill (R6)
        for (int i = 0; i < 80; i++) step(1'b1, 1'b0, W'($urandom), 6'd63, 1'b1, "R6");

        // Read every stage with the chain frozen (R7)
        for (int s = 0; s < 64; s++) step(1'b0, 1'b0, W'($urandom), SW'(s), 1'b1, "R7");

        // Fixed mid delays streaming (R3)
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, W'($urandom), 6'd5, 1'b1, "R3");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, W'($urandom), 6'd1, 1'b1, "R3");

        // Hold with enable low while din toggles (R4)
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, W'($urandom), 6'd17, 1'b1, "R4");

        // Directed retarget across a shift: setting grows by one (R5)
        step(1'b1, 1'b0, 8'h3C, 6'd10, 1'b1, "R5");
        step(1'b1, 1'b0, 8'hC3, 6'd11, 1'b1, "R5");
        step(1'b1, 1'b0, 8'h5A, 6'd0,  1'b1, "R5");
        step(1'b1, 1'b0, 8'hA5, 6'd1,  1'b1, "R5");

        // Random stream with setting changes and enable gaps (R5)
        begin
            logic [SW-1:0] cur = 6'd20;
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 4) == 0) cur = SW'($urandom);
                step(($urandom % 4) != 0, 1'b0, W'($urandom), cur, 1'b1, "R5");
            end
        end

        // Reset mid-stream clears all stages (R1)
        step(1'b1, 1'b1, 8'hFF, 6'd3, 1'b1, "R1");
        for (int s = 1; s < 64; s++) step(1'b0, 1'b0, W'($urandom), SW'(s), 1'b1, "R1");

        // Sweep of every setting after a fresh fill (R3, R7)
        for (int i = 0; i < 64; i++) step(1'b1, 1'b0, W'($urandom), 6'd0, 1'b0, "R3");
        for (int s = 0; s < 64; s++) begin
            step(1'b1, 1'b0, W'($urandom), SW'(s), 1'b1, "R3");
            step(1'b0, 1'b0, W'($urandom), SW'(63 - s), 1'b1, "R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule